// File: doc/BRIEF.md
# Three-Framing Serial Word Output Port

This block holds one 16-bit result word and sends it on a single serial data line. A static two-bit mode input chooses one of three framings. In character mode the word goes out as two framed characters, each bit lasting one period of an externally supplied bit clock. In external-clock synchronous mode the raw 16 bits are shifted out on the falling edges of an incoming serial clock. In self-clocked mode the block generates its own serial clock from the master clock. Because the block has no real tri-state pins, it drives separate output-enable signals for the data line and the clock line.

A producer writes words through a one-cycle parallel load strobe. An active-low data-ready flag tells the host that an unsent word is waiting. Each load forces that flag inactive for a fixed window, and a chip-select falling edge inside this window is dropped. A host starts a transfer by pulling chip select low. If it raises chip select early, the block finishes the bit in flight and then stops driving the line. A word loaded while a transfer is running is held in a shadow register until that transfer ends. The external clock and chip select are synchronised into the master clock domain by two-flop synchronisers, so the external clock must run no faster than half the master clock.

Top module: `tri_mode_sout`

## Requirements
- R1: After reset, ready_n is 1, sdata_oe and sclk_oe are 0, sclk_out is 0 and sdata_out is 1.
- R2: mode_sel encodes the framing as 0 = character, 1 = external-clock synchronous, 2 = self-clocked, and 3 behaves as 1. A transfer begins 3 master cycles after chip select goes low, provided a word is waiting and no load window is open. From that cycle on, sdata_oe is 1.
- R3: In mode 1, the 16 word bits go out most significant bit first. The first bit is on the line when the transfer begins, and each later bit appears after a falling edge of sclk_in. The line is released after the 16th falling edge.
- R4: In mode 0, 22 bits go out, one per sclk_in falling edge. The upper byte is sent first. Each byte is a 0 start bit, then its 8 data bits least significant first, then two 1 stop bits.
- R5: In mode 2, sclk_oe is 1 during the transfer. sclk_out repeats a pattern of high for 1 master cycle and low for 3. The first high comes 3 cycles after the transfer begins. Data changes only as sclk_out falls, most significant bit first, and the line is released when the 16th high ends.
- R6: ready_n is 0 while an unsent word is held and no load window is open. It returns to 1 once a complete word has been transmitted and nothing new is waiting.
- R7: A load strobe forces ready_n to 1 for exactly 4 master cycles after the loading edge. This happens whether or not a transfer is running.
- R8: A chip-select falling edge that is recognised inside a load window is ignored and is not deferred. No transfer starts until chip select rises and falls again.
- R9: If chip select rises during a transfer, the current bit is completed and then sdata_oe (and sclk_oe in mode 2) drops. The aborted word stays valid, so ready_n remains 0.
- R10: A word loaded during a transfer does not disturb the bits being sent. It becomes the waiting word when the transfer ends, so ready_n is 0 afterwards, and the next transfer sends it.
- R11: sdata_out is 1 whenever sdata_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Static framing select |
| word_load | input | 1 | One-cycle strobe that loads word_in |
| word_in | input | 16 | Parallel word to send |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| sclk_in | input | 1 | External bit clock for modes 0, 1 and 3 (asynchronous) |
| sdata_out | output | 1 | Serial data |
| sdata_oe | output | 1 | Output enable for the data line |
| sclk_out | output | 1 | Generated serial clock in mode 2 |
| sclk_oe | output | 1 | Output enable for the clock line |
| ready_n | output | 1 | Active-low data-ready flag |

## Verification
A wrong bit counter or shift register shows as a corrupted or truncated frame on sdata_out. It also shows as sdata_oe dropping one bit period too early or too late, visible within the frame in which the fault occurs. A wrong load window or valid bit shows within a few master cycles, as a ready_n pulse that is not 4 cycles wide or a flag left wrong after a transfer. A shadow-register fault shows on the next transfer, which sends the wrong word. A clock-generator fault shows at once as a gap between sclk_out highs that is not 4 cycles.

// File: rtl/sout_pkg.sv
package sout_pkg;
  localparam int WORD_W     = 16;
  localparam int CHAR_DATA  = 8;
  localparam int START_BITS = 1;
  localparam int STOP_BITS  = 2;
  localparam int CHAR_W     = START_BITS + CHAR_DATA + STOP_BITS;
  localparam int N_CHARS    = WORD_W / CHAR_DATA;
  localparam int FRAME_W    = N_CHARS * CHAR_W;
  localparam int CNT_W      = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    MODE_CHAR = 2'd0,
    MODE_EXT  = 2'd1,
    MODE_SELF = 2'd2,
    MODE_EXTB = 2'd3
  } port_mode_e;

  // Frame is sent from its top bit downward.
  function automatic logic [FRAME_W-1:0] build_frame(input logic is_char,
                                                     input logic [WORD_W-1:0] w);
    logic [FRAME_W-1:0] f;
    int pos;
    f = '0;
    if (is_char) begin
      pos = FRAME_W - 1;
      for (int c = 0; c < N_CHARS; c++) begin
        for (int s = 0; s < START_BITS; s++) begin
          f[pos] = 1'b0;
          pos--;
        end
        for (int b = 0; b < CHAR_DATA; b++) begin
          f[pos] = w[WORD_W - CHAR_DATA*(c+1) + b];
          pos--;
        end
        for (int s = 0; s < STOP_BITS; s++) begin
          f[pos] = 1'b1;
          pos--;
        end
      end
    end else begin
      f[FRAME_W-1 -: WORD_W] = w;
    end
    return f;
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(input logic is_char);
    return is_char ? CNT_W'(FRAME_W) : CNT_W'(WORD_W);
  endfunction
endpackage

// File: rtl/sout_sync.sv
module sout_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic lvl_d
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {(STAGES+1){RST_VAL}};
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign lvl   = pipe[STAGES-1];
  assign lvl_d = pipe[STAGES];
endmodule

// File: rtl/sout_clkgen.sv
module sout_clkgen #(
  parameter int DIV  = 4,
  parameter int HIGH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic sclk_hi,
  output logic tick
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PH_W-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ph <= '0;
    else if (start)                   ph <= PH_W'(HIGH);
    else if (run) begin
      if (int'(ph) == DIV - 1)        ph <= '0;
      else                            ph <= ph + 1'b1;
    end
  end

  assign sclk_hi = run && (int'(ph) < HIGH);
  assign tick    = run && (int'(ph) == HIGH - 1);

  // run-length counters used only by the checks below
  logic [PH_W:0] hi_run, lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else if (!run) begin
      hi_run <= '0;
      lo_run <= '0;
    end else if (sclk_hi) begin
      hi_run <= hi_run + 1'b1;
      lo_run <= '0;
    end else begin
      lo_run <= lo_run + 1'b1;
      hi_run <= '0;
    end
  end

  p_high_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_hi |-> (int'(hi_run) < HIGH));
  p_low_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sclk_hi) |-> (int'(lo_run) < DIV - HIGH));
  p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sclk_hi);
endmodule

// File: rtl/sout_wordbuf.sv
module sout_wordbuf #(
  parameter int WORD_W = 16,
  parameter int HOLD   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              start,
  input  logic              active,
  input  logic              fin_full,
  input  logic              fin_abort,
  output logic [WORD_W-1:0] word_q,
  output logic              valid,
  output logic              busy_zero,
  output logic              ready_n
);
  localparam int HW = $clog2(HOLD + 1);

  logic [HW-1:0]     busy;
  logic [WORD_W-1:0] shadow;
  logic              shadow_v;
  logic              tx_now;
  logic              finishing;

  assign tx_now    = active | start;
  assign finishing = fin_full | fin_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy <= '0;
    else if (load)       busy <= HW'(HOLD);
    else if (busy != '0) busy <= busy - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      valid    <= 1'b0;
      shadow   <= '0;
      shadow_v <= 1'b0;
    end else if (finishing) begin
      if (load) begin
        word_q   <= word_in;
        valid    <= 1'b1;
        shadow_v <= 1'b0;
      end else if (shadow_v) begin
        word_q   <= shadow;
        valid    <= 1'b1;
        shadow_v <= 1'b0;
      end else if (fin_full) begin
        valid    <= 1'b0;
      end
    end else if (load) begin
      if (tx_now) begin
        shadow   <= word_in;
        shadow_v <= 1'b1;
      end else begin
        word_q   <= word_in;
        valid    <= 1'b1;
      end
    end
  end

  assign busy_zero = (busy == '0);
  assign ready_n   = !valid || !busy_zero;

  p_load_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ready_n);
  p_shadow_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_v |-> valid);
endmodule

// File: rtl/sout_shifter.sv
module sout_shifter #(
  parameter int FRAME_W = 22,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   len_in,
  input  logic               adv,
  input  logic               cs_hi,
  output logic               active,
  output logic               sd,
  output logic               fin_full,
  output logic               fin_abort
);
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   left;
  logic               abort_pend;
  logic               last;
  logic               fin;

  assign last      = (left == CNT_W'(1));
  assign fin       = active && adv && (last || abort_pend || cs_hi);
  assign fin_full  = fin && last;
  assign fin_abort = fin && !last;
  assign sd        = sh[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      sh         <= '1;
      left       <= '0;
      abort_pend <= 1'b0;
    end else if (start) begin
      active     <= 1'b1;
      sh         <= frame_in;
      left       <= len_in;
      abort_pend <= 1'b0;
    end else if (active) begin
      if (fin) begin
        active     <= 1'b0;
        abort_pend <= 1'b0;
      end else begin
        if (cs_hi) abort_pend <= 1'b1;
        if (adv) begin
          sh   <= {sh[FRAME_W-2:0], 1'b1};
          left <= left - 1'b1;
        end
      end
    end
  end

  p_release_on_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(adv));
  p_count_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (left != '0));
endmodule

// File: rtl/tri_mode_sout.sv
module tri_mode_sout
  import sout_pkg::*;
#(
  parameter int SCLK_DIV    = 4,
  parameter int SCLK_HIGH   = 1,
  parameter int LOAD_HOLD   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              word_load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              cs_n,
  input  logic              sclk_in,
  output logic              sdata_out,
  output logic              sdata_oe,
  output logic              sclk_out,
  output logic              sclk_oe,
  output logic              ready_n
);
  logic cs_lvl, cs_lvl_d, ck_lvl, ck_lvl_d;
  logic cs_fall, sclk_fall;
  logic is_char, is_self;
  logic start, adv, tick, sclk_hi;
  logic active, sd, fin_full, fin_abort;
  logic valid, busy_zero;
  logic [WORD_W-1:0]  word_q;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   len;

  sout_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .din(cs_n), .lvl(cs_lvl), .lvl_d(cs_lvl_d));
  sout_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ck_sync (
    .clk(clk), .rst_n(rst_n), .din(sclk_in), .lvl(ck_lvl), .lvl_d(ck_lvl_d));

  assign cs_fall   = cs_lvl_d && !cs_lvl;
  assign sclk_fall = ck_lvl_d && !ck_lvl;

  assign is_char = (mode_sel == MODE_CHAR);
  assign is_self = (mode_sel == MODE_SELF);
  assign frame   = build_frame(is_char, word_q);
  assign len     = frame_len(is_char);

  assign start = cs_fall && !active && valid && busy_zero;
  assign adv   = is_self ? tick : sclk_fall;

  sout_wordbuf #(.WORD_W(WORD_W), .HOLD(LOAD_HOLD)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(word_load), .word_in(word_in),
    .start(start), .active(active), .fin_full(fin_full), .fin_abort(fin_abort),
    .word_q(word_q), .valid(valid), .busy_zero(busy_zero), .ready_n(ready_n));

  sout_clkgen #(.DIV(SCLK_DIV), .HIGH(SCLK_HIGH)) u_clk (
    .clk(clk), .rst_n(rst_n), .start(start), .run(active && is_self),
    .sclk_hi(sclk_hi), .tick(tick));

  sout_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_in(frame), .len_in(len),
    .adv(adv), .cs_hi(cs_lvl), .active(active), .sd(sd),
    .fin_full(fin_full), .fin_abort(fin_abort));

  assign sdata_oe  = active;
  assign sclk_oe   = active && is_self;
  assign sdata_out = active ? sd : 1'b1;
  assign sclk_out  = sclk_hi;

  p_clk_needs_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_oe |-> sdata_oe);
  p_tx_has_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe |-> valid);
  p_stable_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_out && $past(sclk_out)) |-> $stable(sdata_out));
  p_idle_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdata_oe) |-> sdata_out);
endmodule

// File: tb/tri_mode_sout_bench.sv
module tri_mode_sout_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 4;
  localparam int WD_LIMIT   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'd1;
  logic        word_load = 1'b0;
  logic [15:0] word_in = '0;
  logic        cs_n = 1'b1;
  logic        sclk_in = 1'b0;
  logic        sdata_out, sdata_oe, sclk_out, sclk_oe, ready_n;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  logic [21:0] rx_acc;
  logic [21:0] exp_q[$];

  tri_mode_sout u_tri_mode_sout (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .word_load(word_load),
    .word_in(word_in), .cs_n(cs_n), .sclk_in(sclk_in), .sdata_out(sdata_out),
    .sdata_oe(sdata_oe), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .ready_n(ready_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected < %0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = b[i];
    return r;
  endfunction

  // expected frames, written as right-aligned bit strings in send order
  task automatic expect_frame(input bit chr, input logic [15:0] w);
    if (chr) exp_q.push_back({1'b0, rev8(w[15:8]), 2'b11, 1'b0, rev8(w[7:0]), 2'b11});
    else     exp_q.push_back({6'b0, w});
  endtask

  task automatic score(input string req);
    logic [21:0] e;
    e = exp_q.pop_front();
    chk(rx_acc == e, req, 32'(rx_acc), 32'(e));
  endtask

  task automatic load_word(input logic [15:0] w);
    @(negedge clk);
    word_in = w; word_load = 1'b1;
    @(negedge clk);
    word_load = 1'b0;
  endtask

  task automatic measure_window(output int n);
    n = 0;
    while (ready_n && n < 10) begin n++; @(negedge clk); end
  endtask

  task automatic cs_cycle;
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
  endtask

  task automatic wait_oe(output int n);
    n = 0;
    while (!sdata_oe && n < 10) begin @(negedge clk); n++; end
  endtask

  task automatic rx_ext(input int nbits, output bit oe_ok);
    oe_ok = 1;
    for (int i = 0; i < nbits; i++) begin
      if (!sdata_oe) oe_ok = 0;
      rx_acc = {rx_acc[20:0], sdata_out};
      sclk_in = 1'b1;
      repeat (H) @(negedge clk);
      sclk_in = 1'b0;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic rx_self(input int nbits, output bit gap_ok);
    int cnt;
    gap_ok = 1;
    for (int i = 0; i < nbits; i++) begin
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (!sclk_out && cnt < 12);
      if ((i == 0 && cnt != 3) || (i > 0 && cnt != 4) || !sclk_oe) gap_ok = 0;
      rx_acc = {rx_acc[20:0], sdata_out};
    end
  endtask

  initial begin
    int n;
    bit ok;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(ready_n == 1'b1, "R1 ready_n after reset", 32'(ready_n), 1);
    chk(!sdata_oe && !sclk_oe && !sclk_out, "R1 enables after reset", {sdata_oe, sclk_oe, sclk_out}, 0);
    chk(sdata_out == 1'b1, "R11 idle line after reset", 32'(sdata_out), 1);

    // R7 load window, R6 flag once settled
    mode_sel = 2'd1;
    load_word(16'hA5C3);
    measure_window(n);
    chk(n == 4, "R7 window width idle", n, 4);
    chk(ready_n == 1'b0, "R6 ready_n low with waiting word", 32'(ready_n), 0);

    // R2/R3 external-clock synchronous transfer
    expect_frame(0, 16'hA5C3);
    rx_acc = '0;
    cs_n = 1'b0;
    wait_oe(n);
    chk(n == 3, "R2 start latency", n, 3);
    rx_ext(16, ok);
    chk(ok, "R3 sdata_oe held through frame", 32'(ok), 1);
    score("R3 msb-first frame");
    chk(!sdata_oe && ready_n, "R6 release and flag after full word", {sdata_oe, ready_n}, 1);
    chk(sdata_out == 1'b1, "R11 idle after transfer", 32'(sdata_out), 1);
    cs_n = 1'b1;

    // R4 character framing
    mode_sel = 2'd0;
    load_word(16'h3C81);
    repeat (6) @(negedge clk);
    expect_frame(1, 16'h3C81);
    rx_acc = '0;
    cs_n = 1'b0;
    wait_oe(n);
    rx_ext(22, ok);
    chk(ok, "R4 sdata_oe held through frame", 32'(ok), 1);
    score("R4 character frame");
    chk(!sdata_oe, "R4 release after 22 bits", 32'(sdata_oe), 0);
    cs_n = 1'b1;

    // R5 self-clocked
    mode_sel = 2'd2;
    load_word(16'h9E17);
    repeat (6) @(negedge clk);
    expect_frame(0, 16'h9E17);
    rx_acc = '0;
    cs_n = 1'b0;
    wait_oe(n);
    chk(sclk_oe == 1'b1, "R5 sclk_oe during transfer", 32'(sclk_oe), 1);
    rx_self(16, ok);
    chk(ok, "R5 sclk spacing 1 high 3 low", 32'(ok), 1);
    score("R5 self-clocked frame");
    @(negedge clk);
    chk(!sclk_oe && !sdata_oe && ready_n, "R5 release after 16th high", {sclk_oe, sdata_oe, ready_n}, 1);
    cs_n = 1'b1;

    // R9 abort in self-clocked mode
    load_word(16'hC3A5);
    repeat (6) @(negedge clk);
    rx_acc = '0;
    cs_n = 1'b0;
    wait_oe(n);
    rx_self(3, ok);
    cs_n = 1'b1;
    n = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (sclk_out) n++;
    end
    chk(n == 1, "R9 self abort finishes one bit", n, 1);
    chk(!sclk_oe && !sdata_oe, "R9 self abort releases both lines", {sclk_oe, sdata_oe}, 0);
    chk(ready_n == 1'b0, "R9 aborted word still valid", 32'(ready_n), 0);

    // R9 abort in external-clock mode
    mode_sel = 2'd1;
    cs_cycle();
    wait_oe(n);
    rx_ext(5, ok);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdata_oe == 1'b1, "R9 bit in flight kept", 32'(sdata_oe), 1);
    sclk_in = 1'b1; repeat (H) @(negedge clk);
    sclk_in = 1'b0; repeat (H) @(negedge clk);
    chk(!sdata_oe && !ready_n && sdata_out, "R9 ext abort release, word valid",
        {sdata_oe, ready_n, sdata_out}, 3'b001);

    // R8 chip-select fall inside load window is dropped
    @(negedge clk);
    word_in = 16'h1234; word_load = 1'b1; cs_n = 1'b0;
    @(negedge clk);
    word_load = 1'b0;
    repeat (10) @(negedge clk);
    chk(sdata_oe == 1'b0, "R8 fall in window ignored", 32'(sdata_oe), 0);
    expect_frame(0, 16'h1234);
    rx_acc = '0;
    cs_cycle();
    wait_oe(n);
    rx_ext(16, ok);
    score("R8 new word sent after fresh fall");
    cs_n = 1'b1;

    // R10 shadow load during transfer, R7 window while busy
    load_word(16'h0F0F);
    repeat (6) @(negedge clk);
    expect_frame(0, 16'h0F0F);
    rx_acc = '0;
    cs_n = 1'b0;
    wait_oe(n);
    rx_ext(3, ok);
    load_word(16'h7001);
    measure_window(n);
    chk(n == 4, "R7 window width during transfer", n, 4);
    rx_ext(13, ok);
    score("R10 running word undisturbed");
    chk(!sdata_oe && !ready_n, "R10 held word now waiting", {sdata_oe, ready_n}, 0);
    expect_frame(0, 16'h7001);
    rx_acc = '0;
    cs_cycle();
    wait_oe(n);
    rx_ext(16, ok);
    score("R10 held word sent next");
    cs_n = 1'b1;

    // R2 mode 3 behaves as mode 1
    mode_sel = 2'd3;
    load_word(16'hBEEF);
    repeat (6) @(negedge clk);
    expect_frame(0, 16'hBEEF);
    rx_acc = '0;
    cs_n = 1'b0;
    wait_oe(n);
    rx_ext(16, ok);
    score("R2 mode 3 raw framing");
    chk(ready_n == 1'b1, "R6 flag after mode 3 word", 32'(ready_n), 1);
    cs_n = 1'b1;

    repeat (4) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule